// File: doc/BRIEF.md
# GPIO Pin Level Resolver

This block works out the level seen on each of a bank of general purpose pins. Three sources can act on a pin: the controller's own output driver, an external driver, and the weak internal pulls. For every pin the controller's output value is first inverted by that pin's polarity bit. The output enable then decides whether the controller drives the pin. In open-drain mode the controller only ever pulls the pin low. An external driver can also drive the pin. A pin that nobody drives settles to its pull, and with no pull at all it floats.

The resolved level goes through the input enable mask and then through the polarity inversion again. The result is the input data word. That word is registered once per clock, so a downstream event detector can compare the value from one cycle with the value from the next. The block also raises a per-pin undefined flag for pins that have two drivers at opposite levels or that float. A single contention flag is high whenever any pin has two drivers at opposite levels.

Top module: `gpio_pin_resolver`

## Requirements
- R1: The controller's drive level for a pin is its out_data bit XOR its polarity bit. When out_en is 1, open_drain is 0 and no external driver is active, pin_level equals that drive level.
- R2: With open_drain set, the controller drives a pin only when out_en is 1 and the drive level is 0. With a drive level of 1 it releases the pin, and the pin then resolves as if the controller were not driving.
- R3: A pin driven only by the external side (ext_drive_en bit 1, controller not driving) takes the value of its ext_level bit.
- R4: When both sides drive a pin, pin_level is the OR of the two levels. If the two levels differ, the pin is in contention, and contention is 1 exactly when at least one pin is in contention.
- R5: A pin that nobody drives reads 1 when its pull_up bit is set, whatever its pull_down bit is.
- R6: A pin that nobody drives, with pull_down set and pull_up clear, reads 0 and is not flagged undefined.
- R7: A pin that nobody drives and that has neither pull enabled reads 0.
- R8: A pin_undef bit is 1 exactly when that pin is in contention or floats, that is, nobody drives it and neither of its pulls is enabled.
- R9: in_data is a register. It is 0 during reset. At each rising clock edge out of reset it loads (pin_level AND in_mask) XOR polarity, using the values present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| out_data | input | NPINS | Controller output value per pin |
| polarity | input | NPINS | Per-pin inversion for both the drive path and the input path |
| out_en | input | NPINS | Controller output enable |
| open_drain | input | NPINS | 1 = pin only driven low by the controller |
| pull_up | input | NPINS | Internal pull-up enable |
| pull_down | input | NPINS | Internal pull-down enable |
| in_mask | input | NPINS | Input enable mask |
| ext_drive_en | input | NPINS | External driver active on the pin |
| ext_level | input | NPINS | Level applied by the external driver |
| pin_level | output | NPINS | Resolved pin level (combinational) |
| pin_undef | output | NPINS | Pin in contention or floating |
| contention | output | 1 | Some pin has opposing drivers |
| in_data | output | NPINS | Registered, masked, polarity-adjusted input word |

## Verification
The assertions assume that every control input holds still from one rising edge to the next. This matters most for the registered input word, whose check looks one cycle back at the pin and mask terms. They also assume that reset is held for at least one edge before any check that looks at past values. The stimulus changes inputs only a short delay after a rising edge and compares results at the falling edge. Reset is held for several cycles at the start.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;

  // Resolved view of one pin.
  typedef struct packed {
    logic level;
    logic clash;
    logic floating;
  } pin_view_t;

  // Level the controller would put on the pin.
  function automatic logic ctl_drive_level(input logic dout, input logic pol);
    return dout ^ pol;
  endfunction

  // Controller drives only when enabled, and in open drain only a low level.
  function automatic logic ctl_drive_active(input logic oe, input logic od,
                                            input logic lvl);
    return oe & ~(od & lvl);
  endfunction

  // Combine both drivers and the pulls for one pin.
  function automatic pin_view_t resolve_pin(input logic c_en, input logic c_lvl,
                                            input logic x_en, input logic x_lvl,
                                            input logic pu, input logic pd);
    pin_view_t v;
    logic      nobody;
    nobody     = ~(c_en | x_en);
    v.level    = (x_en & x_lvl) | (c_en & c_lvl) | (nobody & pu);
    v.clash    = c_en & x_en & (c_lvl ^ x_lvl);
    v.floating = nobody & ~(pu | pd);
    return v;
  endfunction

  // Input path: mask then polarity.
  function automatic logic sample_pin(input logic lvl, input logic msk,
                                      input logic pol);
    return (lvl & msk) ^ pol;
  endfunction

endpackage

// File: rtl/gpio_drive_stage.sv
module gpio_drive_stage #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] out_data,
  input  logic [NPINS-1:0] polarity,
  input  logic [NPINS-1:0] out_en,
  input  logic [NPINS-1:0] open_drain,
  output logic [NPINS-1:0] ctl_level,
  output logic [NPINS-1:0] ctl_drive_en
);
  import gpio_res_pkg::*;

  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    always_comb begin
      ctl_level[i]    = ctl_drive_level(out_data[i], polarity[i]);
      ctl_drive_en[i] = ctl_drive_active(out_en[i], open_drain[i], ctl_level[i]);
    end
  end

endmodule

// File: rtl/gpio_level_merge.sv
module gpio_level_merge #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] ctl_level,
  input  logic [NPINS-1:0] ctl_drive_en,
  input  logic [NPINS-1:0] ext_drive_en,
  input  logic [NPINS-1:0] ext_level,
  input  logic [NPINS-1:0] pull_up,
  input  logic [NPINS-1:0] pull_down,
  output logic [NPINS-1:0] pin_level,
  output logic [NPINS-1:0] pin_clash,
  output logic [NPINS-1:0] pin_float
);
  import gpio_res_pkg::*;

  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    pin_view_t view;
    always_comb begin
      view = resolve_pin(ctl_drive_en[i], ctl_level[i], ext_drive_en[i],
                         ext_level[i], pull_up[i], pull_down[i]);
      pin_level[i] = view.level;
      pin_clash[i] = view.clash;
      pin_float[i] = view.floating;
    end
  end

endmodule

// File: rtl/gpio_input_capture.sv
module gpio_input_capture #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_level,
  input  logic [NPINS-1:0] in_mask,
  input  logic [NPINS-1:0] polarity,
  output logic [NPINS-1:0] in_data
);
  import gpio_res_pkg::*;

  logic [NPINS-1:0] in_next;

  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    always_comb in_next[i] = sample_pin(pin_level[i], in_mask[i], polarity[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) in_data <= '0;
    else        in_data <= in_next;
  end

endmodule

// File: rtl/gpio_pin_resolver.sv
module gpio_pin_resolver #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] out_data,
  input  logic [NPINS-1:0] polarity,
  input  logic [NPINS-1:0] out_en,
  input  logic [NPINS-1:0] open_drain,
  input  logic [NPINS-1:0] pull_up,
  input  logic [NPINS-1:0] pull_down,
  input  logic [NPINS-1:0] in_mask,
  input  logic [NPINS-1:0] ext_drive_en,
  input  logic [NPINS-1:0] ext_level,
  output logic [NPINS-1:0] pin_level,
  output logic [NPINS-1:0] pin_undef,
  output logic             contention,
  output logic [NPINS-1:0] in_data
);

  // Internal events, brought out for the checker.
  logic [NPINS-1:0] ctl_level;
  logic [NPINS-1:0] ctl_drive_en;
  logic [NPINS-1:0] pin_clash;
  logic [NPINS-1:0] pin_float;

  gpio_drive_stage #(.NPINS(NPINS)) u_drive (
    .out_data     (out_data),
    .polarity     (polarity),
    .out_en       (out_en),
    .open_drain   (open_drain),
    .ctl_level    (ctl_level),
    .ctl_drive_en (ctl_drive_en)
  );

  gpio_level_merge #(.NPINS(NPINS)) u_merge (
    .ctl_level    (ctl_level),
    .ctl_drive_en (ctl_drive_en),
    .ext_drive_en (ext_drive_en),
    .ext_level    (ext_level),
    .pull_up      (pull_up),
    .pull_down    (pull_down),
    .pin_level    (pin_level),
    .pin_clash    (pin_clash),
    .pin_float    (pin_float)
  );

  gpio_input_capture #(.NPINS(NPINS)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_level (pin_level),
    .in_mask   (in_mask),
    .polarity  (polarity),
    .in_data   (in_data)
  );

  always_comb begin
    pin_undef  = pin_clash | pin_float;
    contention = |pin_clash;
  end

endmodule

// File: rtl/gpio_pin_resolver_chk.sv
module gpio_pin_resolver_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] out_data,
  input logic [NPINS-1:0] polarity,
  input logic [NPINS-1:0] out_en,
  input logic [NPINS-1:0] open_drain,
  input logic [NPINS-1:0] pull_up,
  input logic [NPINS-1:0] pull_down,
  input logic [NPINS-1:0] in_mask,
  input logic [NPINS-1:0] ext_drive_en,
  input logic [NPINS-1:0] ext_level,
  input logic [NPINS-1:0] pin_level,
  input logic [NPINS-1:0] pin_undef,
  input logic             contention,
  input logic [NPINS-1:0] in_data,
  input logic [NPINS-1:0] ctl_level,
  input logic [NPINS-1:0] ctl_drive_en
);

  // Open-drain pins whose drive level is 1 must not be driven by the controller.
  assert_od_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((open_drain & ctl_level & ctl_drive_en) == '0));

  // Opposing drivers on any pin must raise the contention flag.
  assert_clash_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_drive_en & ext_drive_en & (ctl_level ^ ext_level)) != '0) |-> contention);

  // Contention always shows up in some undefined bit.
  assert_clash_undef_R8: assert property (@(posedge clk) disable iff (!rst_n)
    contention |-> (pin_undef != '0));

  // Undriven pins with a pull-up read high.
  assert_pullup_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ctl_drive_en & ~ext_drive_en & pull_up & ~pin_level) == '0));

  // Undriven pins without a pull-up read low.
  assert_nopull_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ctl_drive_en & ~ext_drive_en & ~pull_up & pin_level) == '0));

  // Registered input word follows the previous cycle's pin view.
  assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (in_data == $past((pin_level & in_mask) ^ polarity)));

endmodule

bind gpio_pin_resolver gpio_pin_resolver_chk #(.NPINS(NPINS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .out_data     (out_data),
  .polarity     (polarity),
  .out_en       (out_en),
  .open_drain   (open_drain),
  .pull_up      (pull_up),
  .pull_down    (pull_down),
  .in_mask      (in_mask),
  .ext_drive_en (ext_drive_en),
  .ext_level    (ext_level),
  .pin_level    (pin_level),
  .pin_undef    (pin_undef),
  .contention   (contention),
  .in_data      (in_data),
  .ctl_level    (ctl_level),
  .ctl_drive_en (ctl_drive_en)
);

// File: tb/tb_gpio_pin_resolver.sv
`timescale 1ns/1ps
module tb_gpio_pin_resolver;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] out_data = '0, polarity = '0, out_en = '0, open_drain = '0;
  logic [N-1:0] pull_up = '0, pull_down = '0, in_mask = '0;
  logic [N-1:0] ext_drive_en = '0, ext_level = '0;
  logic [N-1:0] pin_level, pin_undef, in_data;
  logic contention;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_pin_resolver #(.NPINS(N)) dut (.*);

  // Behavioural reference, one pin at a time.
  logic [N-1:0] m_level, m_undef, m_sample;
  logic m_clash;
  string m_tag [N];

  task automatic model();
    m_clash = 1'b0;
    for (int i = 0; i < N; i++) begin
      bit want_hi, ctl_on, ext_on, pulled_up, pulled_dn;
      want_hi   = (out_data[i] != polarity[i]);
      ctl_on    = out_en[i] && !(open_drain[i] && want_hi);
      ext_on    = ext_drive_en[i];
      pulled_up = pull_up[i];
      pulled_dn = pull_down[i];
      m_undef[i] = 1'b0;
      if (ctl_on && ext_on) begin
        m_level[i] = want_hi || ext_level[i];
        if (want_hi != ext_level[i]) begin m_undef[i] = 1'b1; m_clash = 1'b1; end
        m_tag[i] = "R4";
      end else if (ctl_on) begin
        m_level[i] = want_hi;
        m_tag[i] = open_drain[i] ? "R2" : "R1";
      end else if (ext_on) begin
        m_level[i] = ext_level[i];
        m_tag[i] = (out_en[i] && open_drain[i]) ? "R2" : "R3";
      end else if (pulled_up) begin
        m_level[i] = 1'b1; m_tag[i] = "R5";
      end else if (pulled_dn) begin
        m_level[i] = 1'b0; m_tag[i] = "R6";
      end else begin
        m_level[i] = 1'b0; m_undef[i] = 1'b1; m_tag[i] = "R7";
      end
      m_sample[i] = in_mask[i] ? (m_level[i] != polarity[i]) : polarity[i];
    end
  endtask

  logic [N-1:0] exp_in = '0;
  always @(posedge clk) begin
    model();
    exp_in <= rst_n ? m_sample : '0;
  end

  task automatic check_vec(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    model();
    check_vec("R9 in_data", in_data, exp_in);
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        n_tests++;
        if (pin_level[i] !== m_level[i]) begin
          n_fail++;
          $display("FAIL %s pin %0d level actual=%b expected=%b", m_tag[i], i,
                   pin_level[i], m_level[i]);
        end
      end
      check_vec("R8 pin_undef", pin_undef, m_undef);
      n_tests++;
      if (contention !== m_clash) begin
        n_fail++;
        $display("FAIL R4 contention actual=%b expected=%b", contention, m_clash);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin : stim
    repeat (4) step();
    check_vec("R9 reset value", in_data, '0);
    rst_n = 1'b1;
    // R1: push-pull drive with and without polarity.
    out_en = '1; in_mask = '1; out_data = 32'hA5A5_0F0F; step();
    polarity = 32'hFFFF_0000; step();
    // R2: open drain releases high levels, pulls give the value.
    open_drain = '1; pull_up = 32'h00FF_00FF; pull_down = 32'hFF00_FF00; step();
    polarity = '0; step();
    // R3: external only.
    out_en = '0; open_drain = '0; ext_drive_en = '1; ext_level = 32'h1234_5678; step();
    // R4: both drive, some opposing.
    out_en = '1; out_data = 32'hFFFF_0000; ext_level = 32'hFF00_FF00; step();
    // R4: both drive, all agreeing.
    ext_level = out_data; step();
    // R5, R6, R7: nobody drives.
    out_en = '0; ext_drive_en = '0;
    pull_up = 32'h0000_FFFF; pull_down = 32'h00FF_00FF; step();
    pull_up = '0; pull_down = '0; step();
    // R9: mask and polarity on the input path.
    pull_up = '1; in_mask = 32'h0F0F_0F0F; polarity = 32'h3333_3333; step();
    in_mask = '0; step();
    // Mixed patterns.
    for (int k = 0; k < 200; k++) begin
      out_data = $urandom; polarity = $urandom; out_en = $urandom;
      open_drain = $urandom; pull_up = $urandom; pull_down = $urandom;
      in_mask = $urandom; ext_drive_en = $urandom; ext_level = $urandom;
      step();
    end
    step();
    @(negedge clk); #1;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule